// File: doc/BRIEF.md
# Configurable Asynchronous DRAM Controller

This block connects a simple processor-side request port to a conventional asynchronous DRAM. A held request is taken on a clock edge. The controller then multiplexes the row and column addresses onto a shared address bus and drives RAS, the two CAS strobes and the two WE strobes. It returns read data together with a one-cycle ready pulse. A refresh timer requests CAS-before-RAS refresh cycles at a fixed period. When page mode is on, the row stays open between accesses, so an access to the same row needs only a CAS pulse.

A 16-bit configuration word selects the behaviour. It holds: controller enable, page mode, refresh enable, byte-lane style (per-byte WE or per-byte CAS), a 2-bit row-shift code, and the RAS low time used during refresh. The requester holds `req` and its fields stable until it sees `req_ready`, and drops `req` in that cycle.

Top module: `dram_ctrl`

## Requirements
- R1: The configuration word reads back as 0x0300 after reset. A write stores the written value AND 0x0FCF, so bits 15:12 and 5:4 always read as zero. Field positions: bit 0 enable, bit 1 page mode, bit 2 refresh enable, bit 3 lane style, bits 7:6 row-shift code, bits 11:8 refresh RAS width.
- R2: While bit 0 is 0, a closed controller starts no access and no refresh, even with `req` held high. RAS, CAS and WE stay high and `req_ready` stays low.
- R3: Take an access accepted on edge E while no row is open. The row address shows with RAS low after E. The column phase lasts the next two cycles. `req_ready` is high for exactly the fourth cycle after E, with CAS and WE high.
- R4: The row address is the request address shifted right by 9, 10, 11 or 8 bits for codes 00, 01, 10 and 11. The column address is the address bits below that shift amount. Both are driven on `mem_addr` (MA bits wide); outside the row and column phases `mem_addr` is 0.
- R5: With bit 3 at 0, both CAS strobes fall together in the column phase. On a write, WE strobe i is low only where `req_be[i]` is 1; on a read both WE strobes stay high.
- R6: With bit 3 at 1, CAS strobe i falls only where `req_be[i]` is 1. On a write both WE strobes are low; on a read both stay high.
- R7: With page mode on, RAS stays low after the ready cycle. A following access to the same row skips the row phase: its column phase starts the cycle after the accepting edge.
- R8: An open row is closed when one of these holds: a request for a different row arrives, page mode is turned off, or the controller is disabled. Closing means one precharge cycle with RAS high, then one idle cycle, before the next RAS low.
- R9: With bits 0 and 2 set, a refresh becomes due every REF_PERIOD cycles. In a refresh, both CAS strobes fall one cycle before RAS. With bit 2 clear, no refresh occurs.
- R10: During refresh, RAS stays low for the number of cycles in bits 11:8. A value of 0 gives 1 cycle.
- R11: A due refresh is served before a waiting access. An open row is closed through precharge before the refresh starts.
- R12: After every rise of RAS, RAS stays high for at least two cycles.
- R13: Read data sampled from `mem_dq_in` at the end of the column phase is on `req_rdata` during the ready cycle. During a write column phase `mem_dq_oe` is high and `mem_dq_out` carries the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration read value |
| req | input | 1 | Access request, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_be | input | 2 | Byte enables, bit 1 upper byte |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read data, valid with req_ready |
| mem_addr | output | MA | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 2 | Column strobes, active low |
| mem_we_n | output | 2 | Write strobes, active low |
| mem_dq_out | output | 16 | Data toward the DRAM |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_in | input | 16 | Data from the DRAM |

## Verification
Every pin result comes from registered state, so the first effect of a request or a configuration write appears in the cycle after the edge that samples it. For a new row: row address after one edge, column phase after two and three, ready after four, then precharge and idle when page mode is off. A page hit is one cycle shorter. A refresh takes one CAS-only cycle, the programmed number of RAS cycles, precharge and idle. The bench's behavioural model decides on the same edge as the design, from inputs already held stable. It queues the expected pin values for each later cycle, and all pins are compared at every falling edge against the queue head.

// File: rtl/dramc_pkg.sv
// Shared definitions for the DRAM controller: config word layout, states,
// and the row-shift decode.
package dramc_pkg;

    localparam int DQ_W  = 16;
    localparam int LANES = 2;
    localparam logic [15:0] CFG_RESET = 16'h0300;
    localparam logic [15:0] CFG_MASK  = 16'h0FCF;

    // Configuration word; packed so that bit 0 is the enable.
    typedef struct packed {
        logic [3:0] zero_hi;
        logic [3:0] ref_ras;
        logic [1:0] row_code;
        logic [1:0] zero_mid;
        logic       cas_lanes;
        logic       ref_on;
        logic       page_on;
        logic       ctl_on;
    } dramc_cfg_t;

    typedef enum logic [3:0] {
        S_IDLE, S_ROW, S_COLA, S_COLB, S_ACK, S_OPEN, S_PRE, S_RCAS, S_RRAS
    } dramc_state_e;

    // Row shift amount for a 2-bit code; the encoding is not monotonic.
    function automatic logic [3:0] row_shift(input logic [1:0] code);
        case (code)
            2'b00:   return 4'd9;
            2'b01:   return 4'd10;
            2'b10:   return 4'd11;
            default: return 4'd8;
        endcase
    endfunction

    // Refresh RAS length; a zero field is promoted to one cycle.
    function automatic logic [3:0] ras_cycles(input logic [3:0] f);
        return (f == 4'd0) ? 4'd1 : f;
    endfunction

endpackage

// File: rtl/dramc_cfg_reg.sv
// Configuration word register.
// Assumes: writes are single-cycle strobes; reserved bits are masked on write.
module dramc_cfg_reg
    import dramc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output dramc_cfg_t  cfg
);

    logic [15:0] word_q;

    // Store the masked word on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     word_q <= CFG_RESET;
        else if (wr_en) word_q <= wdata & CFG_MASK;
    end

    assign rdata = word_q;
    assign cfg   = dramc_cfg_t'(word_q);

    // R1: the stored word only changes on a write strobe.
    assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rdata));

endmodule

// File: rtl/dramc_ref_timer.sv
// Refresh interval timer: raises a pending flag every PERIOD running cycles.
// Assumes: 'take' is only asserted while 'pend' is set.
module dramc_ref_timer #(
    parameter int PERIOD = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic take,
    output logic pend
);

    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    // Count while running; a new period end wins over a take in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            pend  <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            pend  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (take) pend <= 1'b0;
        end
    end

    // R9: with refresh stopped, nothing stays pending.
    assert_ref_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !pend);

endmodule

// File: rtl/dramc_addr_mux.sv
// Splits an access address into row and column parts for a selected shift.
// Assumes: AW > MA and MA > 11, so every shift leaves a full column.
module dramc_addr_mux
    import dramc_pkg::*;
#(
    parameter int AW = 22,
    parameter int MA = 12
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    code,
    output logic [MA-1:0] row,
    output logic [MA-1:0] col
);

    logic [3:0]    sh;
    logic [AW-1:0] shifted;
    logic [AW-1:0] low_part;

    // Form the row by shifting and the column by masking below the shift.
    always_comb begin
        sh       = row_shift(code);
        shifted  = addr >> sh;
        low_part = addr & ~({AW{1'b1}} << sh);
        row      = shifted[MA-1:0];
        col      = low_part[MA-1:0];
    end

endmodule

// File: rtl/dramc_seq.sv
// Access and refresh sequencer. Drives RAS, per-lane CAS and WE, and the
// multiplexed address. Holds the row open in page mode.
// Assumes: request fields are held stable until the ready cycle.
module dramc_seq
    import dramc_pkg::*;
#(
    parameter int MA = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dramc_cfg_t       cfg,
    input  logic             ref_pend,
    output logic             ref_take,
    input  logic             req,
    input  logic             req_write,
    input  logic [LANES-1:0] req_be,
    input  logic [DQ_W-1:0]  req_wdata,
    input  logic [MA-1:0]    row_in,
    input  logic [MA-1:0]    col_in,
    input  logic [DQ_W-1:0]  dq_in,
    output logic             ready,
    output logic [DQ_W-1:0]  rdata,
    output logic [MA-1:0]    mem_addr,
    output logic             ras_n,
    output logic [LANES-1:0] cas_n,
    output logic [LANES-1:0] we_n,
    output logic [DQ_W-1:0]  dq_out,
    output logic             dq_oe
);

    dramc_state_e     state, nxt;
    logic [MA-1:0]    lat_row, lat_col;
    logic             lat_we;
    logic [LANES-1:0] lat_be;
    logic [DQ_W-1:0]  lat_wd;
    logic [3:0]       rcnt;
    logic             acc_row, acc_col, col_phase, cbr_phase, row_miss;

    assign row_miss = req && (row_in != lat_row);
    assign ref_take = (state == S_IDLE) && cfg.ctl_on && ref_pend;

    // Next-state choice: refresh first, then new row, page hit, or close.
    always_comb begin
        nxt     = state;
        acc_row = 1'b0;
        acc_col = 1'b0;
        case (state)
            S_IDLE: begin
                if (cfg.ctl_on && ref_pend) nxt = S_RCAS;
                else if (cfg.ctl_on && req) begin
                    nxt     = S_ROW;
                    acc_row = 1'b1;
                end
            end
            S_ROW:  nxt = S_COLA;
            S_COLA: nxt = S_COLB;
            S_COLB: nxt = S_ACK;
            S_ACK:  nxt = cfg.page_on ? S_OPEN : S_PRE;
            S_OPEN: begin
                if (!cfg.ctl_on || !cfg.page_on || ref_pend || row_miss) nxt = S_PRE;
                else if (req) begin
                    nxt     = S_COLA;
                    acc_col = 1'b1;
                end
            end
            S_PRE:  nxt = S_IDLE;
            S_RCAS: nxt = S_RRAS;
            S_RRAS: if (rcnt <= 4'd1) nxt = S_PRE;
            default: nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Latch the request fields when an access is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_row <= '0;
            lat_col <= '0;
            lat_we  <= 1'b0;
            lat_be  <= '0;
            lat_wd  <= '0;
        end else begin
            if (acc_row) lat_row <= row_in;
            if (acc_row || acc_col) begin
                lat_col <= col_in;
                lat_we  <= req_write;
                lat_be  <= req_be;
                lat_wd  <= req_wdata;
            end
        end
    end

    // Capture read data at the end of the column phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                rdata <= '0;
        else if (state == S_COLB) rdata <= dq_in;
    end

    // Refresh RAS length counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                rcnt <= '0;
        else if (state == S_RCAS) rcnt <= ras_cycles(cfg.ref_ras);
        else if (state == S_RRAS) rcnt <= rcnt - 4'd1;
    end

    assign col_phase = (state == S_COLA) || (state == S_COLB);
    assign cbr_phase = (state == S_RCAS) || (state == S_RRAS);

    // RAS and address decode from the current state.
    always_comb begin
        ras_n    = !(state inside {S_ROW, S_COLA, S_COLB, S_ACK, S_OPEN, S_RRAS});
        mem_addr = (state == S_ROW) ? lat_row : (col_phase ? lat_col : '0);
        ready    = (state == S_ACK);
        dq_oe    = col_phase && lat_we;
        dq_out   = lat_wd;
    end

    // Per-lane strobes: the lane style picks which strobe carries the byte select.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign cas_n[i] = cbr_phase ? 1'b0 :
                          col_phase ? (cfg.cas_lanes ? ~lat_be[i] : 1'b0) : 1'b1;
        assign we_n[i]  = (col_phase && lat_we) ? (cfg.cas_lanes ? 1'b0 : ~lat_be[i]) : 1'b1;
    end

    // R12: precharge keeps RAS high for at least two cycles.
    assert_prechg_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> ras_n);
    // R9: in a refresh, CAS was already low when RAS falls.
    assert_cbr_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && (cas_n == '0)) |-> ($past(cas_n) == '0));
    // R3: ready is a single-cycle pulse.
    assert_ready_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    // R2: a disabled controller leaves idle for nothing.
    assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !cfg.ctl_on) |=> (state == S_IDLE));
    // R10: refresh RAS stays low while cycles remain.
    assert_ref_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RRAS && rcnt > 4'd1) |=> (state == S_RRAS && !ras_n));
    // R11: a due refresh closes an open row first.
    assert_ref_close_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OPEN && ref_pend) |=> ras_n);

endmodule

// File: rtl/dram_ctrl.sv
// Top level of the asynchronous DRAM controller: configuration word,
// refresh timer, address split and sequencer.
// Assumes: one requester that holds its request until ready.
module dram_ctrl
    import dramc_pkg::*;
#(
    parameter int AW         = 22,
    parameter int MA         = 12,
    parameter int REF_PERIOD = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [15:0]   cfg_wdata,
    output logic [15:0]   cfg_rdata,
    input  logic          req,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_be,
    input  logic [15:0]   req_wdata,
    output logic          req_ready,
    output logic [15:0]   req_rdata,
    output logic [MA-1:0] mem_addr,
    output logic          mem_ras_n,
    output logic [1:0]    mem_cas_n,
    output logic [1:0]    mem_we_n,
    output logic [15:0]   mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [15:0]   mem_dq_in
);

    dramc_cfg_t    cfg;
    logic          ref_pend, ref_take;
    logic [MA-1:0] row_w, col_w;

    dramc_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .cfg(cfg)
    );

    dramc_ref_timer #(.PERIOD(REF_PERIOD)) u_ref (
        .clk(clk), .rst_n(rst_n), .run(cfg.ctl_on && cfg.ref_on),
        .take(ref_take), .pend(ref_pend)
    );

    dramc_addr_mux #(.AW(AW), .MA(MA)) u_mux (
        .addr(req_addr), .code(cfg.row_code), .row(row_w), .col(col_w)
    );

    dramc_seq #(.MA(MA)) u_seq (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .ref_pend(ref_pend),
        .ref_take(ref_take), .req(req), .req_write(req_write),
        .req_be(req_be), .req_wdata(req_wdata), .row_in(row_w),
        .col_in(col_w), .dq_in(mem_dq_in), .ready(req_ready),
        .rdata(req_rdata), .mem_addr(mem_addr), .ras_n(mem_ras_n),
        .cas_n(mem_cas_n), .we_n(mem_we_n), .dq_out(mem_dq_out),
        .dq_oe(mem_dq_oe)
    );

endmodule

// File: tb/tb_dram_ctrl.sv
module tb_dram_ctrl;

    localparam int AW = 22;
    localparam int MA = 12;
    localparam int REF_P = 64;

    logic clk = 0;
    logic rst_n = 0;
    logic cfg_wr = 0;
    logic [15:0] cfg_wdata = 0;
    logic [15:0] cfg_rdata;
    logic req = 0, req_write = 0;
    logic [AW-1:0] req_addr = 0;
    logic [1:0] req_be = 0;
    logic [15:0] req_wdata = 0;
    logic req_ready;
    logic [15:0] req_rdata;
    logic [MA-1:0] mem_addr;
    logic mem_ras_n;
    logic [1:0] mem_cas_n, mem_we_n;
    logic [15:0] mem_dq_out;
    logic mem_dq_oe;
    logic [15:0] mem_dq_in = 0;

    int checks = 0, failures = 0, cyc = 0, nref = 0;

    always #10 clk = ~clk;  // 50 MHz

    dram_ctrl #(.AW(AW), .MA(MA), .REF_PERIOD(REF_P)) dut (.*);

    // Expected pin values for one cycle.
    typedef struct {
        logic ras; logic [1:0] cas; logic [1:0] we; logic [MA-1:0] a;
        logic rdy; logic oe; logic [15:0] dout; logic [15:0] rdat; int tag;
    } pv_t;

    pv_t q[$];
    pv_t exp_v;
    logic armed = 0, m_open = 0;
    logic [MA-1:0] m_row;
    logic [15:0] mcfg;
    int mcnt, w;
    logic mpend;

    function automatic pv_t pv(input logic ras, input logic [1:0] cas, input logic [1:0] we,
                               input logic [MA-1:0] a, input logic rdy, input logic oe,
                               input logic [15:0] dout, input logic [15:0] rdat, input int tag);
        pv_t v;
        v.ras = ras; v.cas = cas; v.we = we; v.a = a; v.rdy = rdy; v.oe = oe;
        v.dout = dout; v.rdat = rdat; v.tag = tag;
        return v;
    endfunction

    function automatic int shamt(input logic [1:0] c);
        return (c == 2'b11) ? 8 : 9 + int'(c);
    endfunction

    function automatic logic [MA-1:0] mrow(input logic [AW-1:0] a);
        logic [AW-1:0] t;
        t = a >> shamt(mcfg[7:6]);
        return t[MA-1:0];
    endfunction

    function automatic logic [MA-1:0] mcol(input logic [AW-1:0] a);
        logic [AW-1:0] t;
        t = a & ((22'd1 << shamt(mcfg[7:6])) - 22'd1);
        return t[MA-1:0];
    endfunction

    // Push one access waveform: optional row cycle (R3, R4), column (R5/R6), ready (R13).
    task automatic push_access(input logic new_row);
        logic [1:0] c, wv;
        logic bw;
        bw = mcfg[3];
        if (new_row) begin
            m_row = mrow(req_addr);
            q.push_back(pv(0, 2'b11, 2'b11, m_row, 0, 0, 0, 0, 4));   // R4 row part
        end
        c  = bw ? ~req_be : 2'b00;
        wv = req_write ? (bw ? 2'b00 : ~req_be) : 2'b11;
        repeat (2) q.push_back(pv(0, c, wv, mcol(req_addr), 0, req_write, req_wdata, 0, bw ? 6 : 5));
        q.push_back(pv(0, 2'b11, 2'b11, 0, 1, 0, 0, mem_dq_in, 13)); // R13 ready with data
        if (mcfg[1]) begin
            q.push_back(pv(0, 2'b11, 2'b11, 0, 0, 0, 0, 0, 7));      // R7 row kept open
            m_open = 1;
        end else begin
            q.push_back(pv(1, 2'b11, 2'b11, 0, 0, 0, 0, 0, 12));     // R12 precharge
            q.push_back(pv(1, 2'b11, 2'b11, 0, 0, 0, 0, 0, 3));
            m_open = 0;
        end
    endtask

    // Behavioural reference: decides on the same edge, queues later cycles.
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            exp_v = pv(1, 2'b11, 2'b11, 0, 0, 0, 0, 0, 1);
            m_open = 0; mcfg = 16'h0300; mcnt = 0; mpend = 0; armed = 1;
        end else begin
            if (q.size() == 0) begin
                if (!m_open) begin
                    if (mcfg[0] && mpend) begin              // R11 refresh before access
                        mpend = 0;
                        w = (mcfg[11:8] == 0) ? 1 : int'(mcfg[11:8]);
                        q.push_back(pv(1, 2'b00, 2'b11, 0, 0, 0, 0, 0, 9));
                        repeat (w) q.push_back(pv(0, 2'b00, 2'b11, 0, 0, 0, 0, 0, 10));
                        q.push_back(pv(1, 2'b11, 2'b11, 0, 0, 0, 0, 0, 12));
                        q.push_back(pv(1, 2'b11, 2'b11, 0, 0, 0, 0, 0, 11));
                    end else if (mcfg[0] && req) push_access(1);
                end else begin
                    if (!mcfg[0] || !mcfg[1] || mpend || (req && mrow(req_addr) != m_row)) begin
                        q.push_back(pv(1, 2'b11, 2'b11, 0, 0, 0, 0, 0, 8)); // R8 close
                        q.push_back(pv(1, 2'b11, 2'b11, 0, 0, 0, 0, 0, 8));
                        m_open = 0;
                    end else if (req) push_access(0);
                end
            end
            if (q.size() != 0) exp_v = q.pop_front();
            else if (m_open) exp_v = pv(0, 2'b11, 2'b11, 0, 0, 0, 0, 0, 7);
            else exp_v = pv(1, 2'b11, 2'b11, 0, 0, 0, 0, 0, 2);
            if (!(mcfg[0] && mcfg[2])) begin mcnt = 0; mpend = 0; end
            else if (mcnt == REF_P - 1) begin mcnt = 0; mpend = 1; end
            else mcnt++;
            if (cfg_wr) mcfg = cfg_wdata & 16'h0FCF;
        end
    end

    // Compare every pin against the model at each falling edge.
    logic prev_ras = 1;
    always @(negedge clk) begin
        if (armed && rst_n) begin
            checks++;
            if (mem_ras_n !== exp_v.ras || mem_cas_n !== exp_v.cas || mem_we_n !== exp_v.we ||
                mem_addr !== exp_v.a || req_ready !== exp_v.rdy || mem_dq_oe !== exp_v.oe ||
                (exp_v.oe && mem_dq_out !== exp_v.dout) || (exp_v.rdy && req_rdata !== exp_v.rdat)) begin
                failures++;
                $display("FAIL R%0d t=%0t act ras=%b cas=%b we=%b a=%h rdy=%b oe=%b do=%h rd=%h exp ras=%b cas=%b we=%b a=%h rdy=%b oe=%b do=%h rd=%h",
                    exp_v.tag, $time, mem_ras_n, mem_cas_n, mem_we_n, mem_addr, req_ready, mem_dq_oe,
                    mem_dq_out, req_rdata, exp_v.ras, exp_v.cas, exp_v.we, exp_v.a, exp_v.rdy,
                    exp_v.oe, exp_v.dout, exp_v.rdat);
            end
            if (prev_ras && !mem_ras_n && mem_cas_n == 2'b00) nref++;
            prev_ras = mem_ras_n;
        end
    end

    task automatic check(input string rq, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
        end
    endtask

    task automatic cfg_write(input logic [15:0] v);
        @(negedge clk); cfg_wr = 1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 0;
    endtask

    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [1:0] be,
                          input logic [15:0] wd, input logic [15:0] din);
        int n;
        @(negedge clk);
        req = 1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd; mem_dq_in = din;
        n = 0;
        do begin @(negedge clk); n++; end while (!req_ready && n < 300);
        check("R3 ready seen", int'(req_ready), 1);
        req = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seen, base;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset value", int'(cfg_rdata), 16'h0300);
        cfg_write(16'hFFFF);
        check("R1 reserved bits zero", int'(cfg_rdata), 16'h0FCF);
        // R2: disabled controller ignores a held request.
        cfg_write(16'h0300);
        @(negedge clk); req = 1; req_addr = 22'h012345; seen = 0;
        repeat (12) begin @(negedge clk); if (req_ready) seen++; end
        req = 0;
        check("R2 no ready while disabled", seen, 0);
        // R3 R5 R13: two-WE lanes, code 00.
        cfg_write(16'h0301);
        access(1, 22'h03A5F1, 2'b01, 16'hBEEF, 16'h0000);
        access(0, 22'h03A5F1, 2'b11, 16'h0000, 16'h5A3C);
        check("R13 read data", int'(req_rdata), 16'h5A3C);
        access(1, 22'h1FFFFF, 2'b10, 16'h1234, 16'h0000);
        // R6: two-CAS lanes.
        cfg_write(16'h0309);
        access(1, 22'h0A0B0C, 2'b10, 16'hC0DE, 16'h0000);
        access(0, 22'h0A0B0C, 2'b01, 16'h0000, 16'h7E81);
        // R4: remaining row-shift codes.
        cfg_write(16'h0341); access(0, 22'h2ABCD5, 2'b11, 0, 16'h1111);
        cfg_write(16'h0381); access(0, 22'h2ABCD5, 2'b11, 0, 16'h2222);
        cfg_write(16'h03C1); access(0, 22'h2ABCD5, 2'b11, 0, 16'h3333);
        // R7 R8: page hit, page miss, then page mode switched off.
        cfg_write(16'h0303);
        access(0, 22'h004010, 2'b11, 0, 16'hAAAA);
        access(1, 22'h004011, 2'b11, 16'h5555, 0);
        access(0, 22'h0040FF, 2'b01, 0, 16'h0F0F);
        access(0, 22'h008010, 2'b11, 0, 16'hF0F0);
        idle(3);
        cfg_write(16'h0301);
        idle(6);
        // R9 R10: refresh with width 5, then width 0.
        base = nref;
        cfg_write(16'h0505);
        idle(150);
        check("R9 refresh occurred", int'(nref - base >= 2), 1);
        cfg_write(16'h0005);
        idle(100);
        // R11: page mode plus refresh with a stream of accesses.
        cfg_write(16'h0307);
        for (int i = 0; i < 24; i++)
            access(i % 3 == 0, 22'h010000 + 22'(i * 3), 2'b11, 16'(i), 16'(i * 7));
        idle(10);
        // R9: refresh off means no refresh cycles.
        cfg_write(16'h0301);
        idle(20);
        base = nref;
        idle(150);
        check("R9 no refresh when off", nref - base, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule